// File: doc/BRIEF.md
# Per-register in-order writer scoreboard

This block keeps, for every architectural register of an in-order pipeline, an ordered list of the sequence tags of the instructions that have not yet retired and will write that register. Issue logic uses it to decide three things. A reader may take its operand from the register file when no older writer is pending. A writer may update the file when it is not younger than the oldest pending writer. An operand may come from an older in-flight result when the youngest older writer has finished executing. The block stores tags and executed flags only. It holds no register data and has no forwarding datapath.

One command is accepted per cycle. Each command carries a tag and up to two destination indices: insert, retire, squash or mark-executed. The query ports are combinational. A read port returns read permission, the forwarding source, the bypass candidate and the list depth for one register. A separate write port returns write permission for another register. Tag comparisons are plain unsigned comparisons, so the pipeline must keep the tags in flight inside a window that does not wrap.

Top module: `writer_scoreboard`

## Requirements
- R1: Command codes on `cmd_op` are 0 insert, 1 retire, 2 squash, 3 mark-executed. An insert appends `cmd_tag` to the tail of each enabled destination list, destination 0 first, with its executed flag clear. When both destinations name one register, the tag is appended twice. `rd_depth` reports the number of pending writers of `rd_reg`.
- R2: `rd_ok` is 1 when the list of `rd_reg` is empty or when `rd_tag` is less than or equal to the head tag, and 0 otherwise.
- R3: `wr_ok` applies the same rule to `wr_reg` and `wr_tag`, independently of the read port.
- R4: Scanning from the head while entries are older than `rd_tag`, the last such entry is the forwarding candidate. `fwd_ok` is 1 and `fwd_tag` carries its tag only if the entry was marked executed by a command in an earlier cycle. A mark in the current cycle is not yet visible.
- R5: When no entry of the list is older than `rd_tag`, `fwd_ok` is 0 and `fwd_tag` is 0.
- R6: A retire acts on destination 0 only. If that list is non-empty and its head equals `cmd_tag`, the head is removed. Otherwise the list is left unchanged and `err_retire` is 1 in the following cycle.
- R7: A squash removes the first entry equal to `cmd_tag` from each enabled destination list (two entries when both destinations name one register). The remaining entries keep their order. A tag that is not present leaves the list unchanged.
- R8: A mark-executed command sets the executed flag of every entry equal to `cmd_tag` in the enabled destination lists. List lengths do not change.
- R9: `byp_ok` is 0 when the list of `rd_reg` holds fewer than two entries. Otherwise `byp_ok` and `byp_tag` report the first executed entry after the head, with `byp_tag` 0 when there is none.
- R10: An insert that would push a list beyond its depth leaves that list unchanged, while other named lists are still appended. `err_overflow` is 1 in the following cycle.
- R11: A synchronous active-low reset empties every list and clears both error outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Command code (R1) |
| cmd_tag | input | TAGW | Sequence tag of the instruction |
| cmd_d0_en | input | 1 | Destination 0 enabled |
| cmd_d0 | input | log2(NREG) | Destination 0 register index |
| cmd_d1_en | input | 1 | Destination 1 enabled (ignored by retire) |
| cmd_d1 | input | log2(NREG) | Destination 1 register index |
| rd_reg | input | log2(NREG) | Register queried by the read port |
| rd_tag | input | TAGW | Tag of the reading instruction |
| wr_reg | input | log2(NREG) | Register queried by the write port |
| wr_tag | input | TAGW | Tag of the writing instruction |
| rd_ok | output | 1 | Register file read permitted |
| wr_ok | output | 1 | Register file write permitted |
| fwd_ok | output | 1 | Forwarding source available |
| fwd_tag | output | TAGW | Tag of the forwarding source |
| byp_ok | output | 1 | Executed entry found after the head |
| byp_tag | output | TAGW | Tag of that entry |
| rd_depth | output | log2(DEPTH+1) | Pending writers of rd_reg |
| err_overflow | output | 1 | Previous insert overflowed a list |
| err_retire | output | 1 | Previous retire did not match the head |

## Verification
The hardest state to reach is a full list whose forwarding candidate sits in the middle or at the tail. Older entries are executed and younger ones are not, so the scan must stop at the right place. Squashing such a list then has to remove a duplicated tag from inside it. The stimulus gets there by inserting one instruction whose two destinations name the same register, on top of two older writers that were already marked executed. It then overflows that full list and squashes the duplicate, and it queries between every step with tags chosen to fall between the entries. A directed step drives a mark-executed command and a forwarding query in the same cycle to show that the new flag appears only after the edge.

// File: rtl/wsb_pkg.sv
// Shared definitions for the writer scoreboard.
// Assumes one command per cycle; the code values are part of the port contract.
package wsb_pkg;

    typedef enum logic [1:0] {
        OP_INSERT = 2'd0,
        OP_RETIRE = 2'd1,
        OP_SQUASH = 2'd2,
        OP_EXEC   = 2'd3
    } wsb_op_e;

endpackage

// File: rtl/wsb_lane.sv
// One register's pending-writer list.
// Holds up to DEPTH tags, oldest at index 0, each with an executed flag.
// Each cycle it applies the command that names it (hits = number of
// destination fields naming this register). A retire or squash drops
// entries and the survivors are compacted toward the head in their
// original order. An insert then appends at the tail. Overflow and retire
// mismatches are reported combinationally for the top to register.
// Assumes DEPTH >= 2 and that tags do not wrap while entries are pending.
module wsb_lane
    import wsb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int TAGW  = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  wsb_op_e                 op,
    input  logic [TAGW-1:0]         cmd_tag,
    input  logic [1:0]              hits,
    output logic [DEPTH*TAGW-1:0]   ent_tags,
    output logic [DEPTH-1:0]        ent_done,
    output logic [CW-1:0]           ent_cnt,
    output logic                    ovf_flag,
    output logic                    ret_flag
);

    logic [TAGW-1:0]  tag_q [DEPTH];
    logic [DEPTH-1:0] done_q;
    logic [CW-1:0]    cnt_q;

    logic [TAGW-1:0]  n_tag [DEPTH];
    logic [DEPTH-1:0] n_done;
    logic [CW-1:0]    n_cnt;

    // Next-state computation: keep mask, executed marks, compaction, append.
    always_comb begin
        logic [DEPTH-1:0] keep;
        logic [DEPTH-1:0] mark;
        int app;
        int rm;
        int k;
        keep     = '0;
        mark     = '0;
        app      = 0;
        rm       = 0;
        k        = 0;
        ovf_flag = 1'b0;
        ret_flag = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            keep[i] = (CW'(i) < cnt_q);
        end
        if (cmd_valid && hits != 2'd0) begin
            case (op)
                OP_INSERT: begin
                    if (int'(cnt_q) + int'(hits) > DEPTH) begin
                        ovf_flag = 1'b1;
                    end else begin
                        app = int'(hits);
                    end
                end
                OP_RETIRE: begin
                    if (cnt_q == '0 || tag_q[0] != cmd_tag) begin
                        ret_flag = 1'b1;
                    end else begin
                        keep[0] = 1'b0;
                    end
                end
                OP_SQUASH: begin
                    for (int i = 0; i < DEPTH; i++) begin
                        if (keep[i] && tag_q[i] == cmd_tag && rm < int'(hits)) begin
                            keep[i] = 1'b0;
                            rm++;
                        end
                    end
                end
                OP_EXEC: begin
                    for (int i = 0; i < DEPTH; i++) begin
                        mark[i] = keep[i] && (tag_q[i] == cmd_tag);
                    end
                end
                default: ;
            endcase
        end
        for (int i = 0; i < DEPTH; i++) begin
            n_tag[i] = '0;
        end
        n_done = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (keep[i] && k < DEPTH) begin
                n_tag[k[IW-1:0]]  = tag_q[i];
                n_done[k[IW-1:0]] = done_q[i] | mark[i];
                k++;
            end
        end
        for (int j = 0; j < 2; j++) begin
            if (j < app && k < DEPTH) begin
                n_tag[k[IW-1:0]]  = cmd_tag;
                n_done[k[IW-1:0]] = 1'b0;
                k++;
            end
        end
        n_cnt = CW'(k);
    end

    // List state registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tag_q[i] <= '0;
            end
            done_q <= '0;
            cnt_q  <= '0;
        end else begin
            tag_q  <= n_tag;
            done_q <= n_done;
            cnt_q  <= n_cnt;
        end
    end

    // Flatten the entries for the query logic.
    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign ent_tags[g*TAGW +: TAGW] = tag_q[g];
    end
    assign ent_done = done_q;
    assign ent_cnt  = cnt_q;

    // R10: a list never holds more than DEPTH entries.
    assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) <= DEPTH);

    // R10: an overflowing insert leaves the list length unchanged.
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_INSERT && hits != 2'd0 &&
         int'(cnt_q) + int'(hits) > DEPTH) |=> $stable(cnt_q));

    // R1: a single-destination insert into a non-full list grows it by one.
    assert_insert_grow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_INSERT && hits == 2'd1 && int'(cnt_q) < DEPTH)
        |=> (cnt_q == $past(cnt_q) + CW'(1)));

    // R6: a matching retire shifts the second entry to the head.
    assert_retire_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_RETIRE && hits != 2'd0 && cnt_q > CW'(1) &&
         tag_q[0] == cmd_tag) |=> (tag_q[0] == $past(tag_q[1])));

    // R6: a mismatched retire leaves the list length unchanged.
    assert_retire_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_RETIRE && hits != 2'd0 &&
         (cnt_q == '0 || tag_q[0] != cmd_tag)) |=> $stable(cnt_q));

    // R8: marking executed never changes the list length.
    assert_exec_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_EXEC) |=> $stable(cnt_q));

endmodule

// File: rtl/wsb_lookup.sv
// Read-side query over one selected list.
// Gives read permission from the head tag. It finds the youngest entry
// older than the requester by scanning from the head, and the first
// executed entry after the head. Purely combinational apart from the
// clock used by its assertions.
// Assumes DEPTH >= 2 and unsigned, non-wrapping tags.
module wsb_lookup #(
    parameter int DEPTH = 4,
    parameter int TAGW  = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DEPTH*TAGW-1:0] ent_tags,
    input  logic [DEPTH-1:0]      ent_done,
    input  logic [CW-1:0]         ent_cnt,
    input  logic [TAGW-1:0]       req_tag,
    output logic                  rd_ok,
    output logic                  fwd_ok,
    output logic [TAGW-1:0]       fwd_tag,
    output logic                  byp_ok,
    output logic [TAGW-1:0]       byp_tag
);

    // Read permission against the oldest pending writer.
    always_comb begin
        rd_ok = (ent_cnt == '0) || (req_tag <= ent_tags[TAGW-1:0]);
    end

    // Forward scan: keep the last entry older than the requester.
    always_comb begin
        logic scanning;
        logic found;
        logic sel_done;
        logic [TAGW-1:0] sel_tag;
        scanning = 1'b1;
        found    = 1'b0;
        sel_done = 1'b0;
        sel_tag  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (scanning && CW'(i) < ent_cnt && ent_tags[i*TAGW +: TAGW] < req_tag) begin
                found    = 1'b1;
                sel_tag  = ent_tags[i*TAGW +: TAGW];
                sel_done = ent_done[i];
            end else begin
                scanning = 1'b0;
            end
        end
        fwd_ok  = found && sel_done;
        fwd_tag = (found && sel_done) ? sel_tag : '0;
    end

    // Bypass scan: first executed entry behind the head.
    always_comb begin
        byp_ok  = 1'b0;
        byp_tag = '0;
        if (ent_cnt >= CW'(2)) begin
            for (int i = 1; i < DEPTH; i++) begin
                if (!byp_ok && CW'(i) < ent_cnt && ent_done[i]) begin
                    byp_ok  = 1'b1;
                    byp_tag = ent_tags[i*TAGW +: TAGW];
                end
            end
        end
    end

    // R4: a forwarding source is always strictly older than the requester.
    assert_fwd_older_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_ok |-> (fwd_tag < req_tag));

    // R9: a bypass candidate needs at least two entries.
    assert_byp_depth_R9: assert property (@(posedge clk) disable iff (!rst_n)
        byp_ok |-> (ent_cnt >= CW'(2)));

    // R2: an empty list always permits the read.
    assert_empty_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_cnt == '0) |-> rd_ok);

endmodule

// File: rtl/writer_scoreboard.sv
// Per-register in-order writer scoreboard, top level.
// Decodes one command per cycle into per-register hit counts, keeps one
// wsb_lane per register and answers a read query and a write query
// combinationally. Error outputs are registered one cycle after the
// command that caused them.
// Assumes NREG is a power of two, so every index is valid, and that tags
// stay in a non-wrapping window.
module writer_scoreboard
    import wsb_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int DEPTH = 4,
    parameter int TAGW  = 8,
    localparam int RW   = $clog2(NREG),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [1:0]      cmd_op,
    input  logic [TAGW-1:0] cmd_tag,
    input  logic            cmd_d0_en,
    input  logic [RW-1:0]   cmd_d0,
    input  logic            cmd_d1_en,
    input  logic [RW-1:0]   cmd_d1,
    input  logic [RW-1:0]   rd_reg,
    input  logic [TAGW-1:0] rd_tag,
    input  logic [RW-1:0]   wr_reg,
    input  logic [TAGW-1:0] wr_tag,
    output logic            rd_ok,
    output logic            wr_ok,
    output logic            fwd_ok,
    output logic [TAGW-1:0] fwd_tag,
    output logic            byp_ok,
    output logic [TAGW-1:0] byp_tag,
    output logic [CW-1:0]   rd_depth,
    output logic            err_overflow,
    output logic            err_retire
);

    wsb_op_e op_e;
    assign op_e = wsb_op_e'(cmd_op);

    logic [DEPTH*TAGW-1:0] l_tags [NREG];
    logic [DEPTH-1:0]      l_done [NREG];
    logic [CW-1:0]         l_cnt  [NREG];
    logic [NREG-1:0]       l_ovf;
    logic [NREG-1:0]       l_ret;

    // One lane per register; the hit count selects which lanes act.
    for (genvar r = 0; r < NREG; r++) begin : g_lane
        logic       h0;
        logic       h1;
        logic [1:0] hits;
        assign h0   = cmd_d0_en && (cmd_d0 == RW'(r));
        assign h1   = cmd_d1_en && (cmd_d1 == RW'(r)) && (op_e != OP_RETIRE);
        assign hits = {1'b0, h0} + {1'b0, h1};

        wsb_lane #(
            .DEPTH (DEPTH),
            .TAGW  (TAGW)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd_valid (cmd_valid),
            .op        (op_e),
            .cmd_tag   (cmd_tag),
            .hits      (hits),
            .ent_tags  (l_tags[r]),
            .ent_done  (l_done[r]),
            .ent_cnt   (l_cnt[r]),
            .ovf_flag  (l_ovf[r]),
            .ret_flag  (l_ret[r])
        );
    end

    // Read port: select the queried list and evaluate it.
    wsb_lookup #(
        .DEPTH (DEPTH),
        .TAGW  (TAGW)
    ) u_rd_lookup (
        .clk      (clk),
        .rst_n    (rst_n),
        .ent_tags (l_tags[rd_reg]),
        .ent_done (l_done[rd_reg]),
        .ent_cnt  (l_cnt[rd_reg]),
        .req_tag  (rd_tag),
        .rd_ok    (rd_ok),
        .fwd_ok   (fwd_ok),
        .fwd_tag  (fwd_tag),
        .byp_ok   (byp_ok),
        .byp_tag  (byp_tag)
    );
    assign rd_depth = l_cnt[rd_reg];

    // Write port: permission from the head of a separately selected list.
    logic [DEPTH*TAGW-1:0] wr_list;
    logic [CW-1:0]         wr_cnt;
    always_comb begin
        wr_list = l_tags[wr_reg];
        wr_cnt  = l_cnt[wr_reg];
        wr_ok   = (wr_cnt == '0) || (wr_tag <= wr_list[TAGW-1:0]);
    end

    // Error pulses, one cycle after the offending command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_overflow <= 1'b0;
            err_retire   <= 1'b0;
        end else begin
            err_overflow <= |l_ovf;
            err_retire   <= |l_ret;
        end
    end

    // R11: the cycle after reset shows no errors and an empty queried list.
    assert_reset_clear_R11: assert property (@(posedge clk)
        !rst_n |=> (!err_overflow && !err_retire && rd_depth == '0));

    // R6: a retire error only follows a retire command.
    assert_retire_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_retire |-> $past(cmd_valid && cmd_op == 2'd1));

    // R10: an overflow error only follows an insert command.
    assert_ovf_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_overflow |-> $past(cmd_valid && cmd_op == 2'd0));

endmodule

// File: tb/writer_scoreboard_tb.sv
// Self-checking bench: a vector table walked by one loop, then directed tests.
module writer_scoreboard_tb;

    localparam int NREG  = 32;
    localparam int DEPTH = 4;
    localparam int TAGW  = 8;
    localparam int RW    = $clog2(NREG);
    localparam int CW    = $clog2(DEPTH + 1);

    logic            clk = 1'b0;
    logic            rst_n;
    logic            cmd_valid;
    logic [1:0]      cmd_op;
    logic [TAGW-1:0] cmd_tag;
    logic            cmd_d0_en;
    logic [RW-1:0]   cmd_d0;
    logic            cmd_d1_en;
    logic [RW-1:0]   cmd_d1;
    logic [RW-1:0]   rd_reg;
    logic [TAGW-1:0] rd_tag;
    logic [RW-1:0]   wr_reg;
    logic [TAGW-1:0] wr_tag;
    logic            rd_ok;
    logic            wr_ok;
    logic            fwd_ok;
    logic [TAGW-1:0] fwd_tag;
    logic            byp_ok;
    logic [TAGW-1:0] byp_tag;
    logic [CW-1:0]   rd_depth;
    logic            err_overflow;
    logic            err_retire;

    int nchk = 0;
    int nerr = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    writer_scoreboard #(.NREG(NREG), .DEPTH(DEPTH), .TAGW(TAGW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_tag(cmd_tag), .cmd_d0_en(cmd_d0_en), .cmd_d0(cmd_d0),
        .cmd_d1_en(cmd_d1_en), .cmd_d1(cmd_d1), .rd_reg(rd_reg),
        .rd_tag(rd_tag), .wr_reg(wr_reg), .wr_tag(wr_tag), .rd_ok(rd_ok),
        .wr_ok(wr_ok), .fwd_ok(fwd_ok), .fwd_tag(fwd_tag), .byp_ok(byp_ok),
        .byp_tag(byp_tag), .rd_depth(rd_depth), .err_overflow(err_overflow),
        .err_retire(err_retire)
    );

    typedef struct packed {
        logic [1:0] op;
        logic [7:0] tag;
        logic       d0e;
        logic [4:0] d0;
        logic       d1e;
        logic [4:0] d1;
        logic [4:0] qr;
        logic [7:0] qt;
        logic       e_rd;
        logic       e_fwd;
        logic [7:0] e_ftag;
        logic       e_byp;
        logic [7:0] e_btag;
        logic [2:0] e_dep;
        logic       e_ovf;
        logic       e_ret;
    } vec_t;

    localparam int NV = 19;
    // Fields: op tag d0e d0 d1e d1 | qreg qtag | rd fwd ftag byp btag depth ovf ret
    localparam vec_t VEC [NV] = '{
        '{0, 10, 1, 5, 0, 0,  5, 20,  0, 0,  0, 0,  0, 1, 0, 0}, // R1 insert
        '{0, 12, 1, 5, 1, 7,  5, 11,  0, 0,  0, 0,  0, 2, 0, 0}, // R1 two regs
        '{3, 10, 1, 5, 0, 0,  5, 11,  0, 1, 10, 0,  0, 2, 0, 0}, // R8 exec head, R4
        '{3, 12, 1, 5, 1, 7,  5, 30,  0, 1, 12, 1, 12, 2, 0, 0}, // R8 R9
        '{0, 14, 1, 5, 1, 5,  5, 13,  0, 1, 12, 1, 12, 4, 0, 0}, // R1 same reg twice
        '{0, 16, 1, 5, 0, 0,  5, 15,  0, 0,  0, 1, 12, 4, 1, 0}, // R10 overflow, R4 not done
        '{2, 14, 1, 5, 1, 5,  5,  5,  1, 0,  0, 1, 12, 2, 0, 0}, // R7 duplicate squash, R5
        '{1, 12, 1, 5, 0, 0,  5, 10,  1, 0,  0, 1, 12, 2, 0, 1}, // R6 mismatch, R5 equal tag
        '{1, 10, 1, 5, 0, 0,  5, 20,  0, 1, 12, 0,  0, 1, 0, 0}, // R6 pop, R9 single
        '{2, 99, 1, 7, 0, 0,  7, 13,  0, 1, 12, 0,  0, 1, 0, 0}, // R7 absent tag
        '{1, 12, 1, 5, 0, 0,  5, 50,  1, 0,  0, 0,  0, 0, 0, 0}, // R6 pop to empty
        '{1, 12, 1, 5, 0, 0,  5, 50,  1, 0,  0, 0,  0, 0, 0, 1}, // R6 retire on empty
        '{0, 20, 1, 3, 1, 4,  4, 20,  1, 0,  0, 0,  0, 1, 0, 0}, // R2 equal head
        '{0, 22, 1, 4, 0, 0,  4, 21,  0, 0,  0, 0,  0, 2, 0, 0}, // R4 older not executed
        '{2, 20, 1, 4, 0, 0,  4, 25,  0, 0,  0, 0,  0, 1, 0, 0}, // R7 squash head
        '{0, 24, 1, 4, 0, 0,  4, 23,  0, 0,  0, 0,  0, 2, 0, 0}, // R1
        '{0, 26, 1, 4, 0, 0,  4, 30,  0, 0,  0, 0,  0, 3, 0, 0}, // R1
        '{2, 24, 1, 4, 0, 0,  4, 23,  0, 0,  0, 0,  0, 2, 0, 0}, // R7 squash middle
        '{3, 26, 1, 4, 0, 0,  4, 30,  0, 1, 26, 1, 26, 2, 0, 0}  // R7 order kept, R8
    };

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one command for one cycle; returns just after the edge settles.
    task automatic do_cmd(input int op, input int tag, input bit d0e, input int d0,
                          input bit d1e, input int d1);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 2'(op);
        cmd_tag   = TAGW'(tag);
        cmd_d0_en = d0e;
        cmd_d0    = RW'(d0);
        cmd_d1_en = d1e;
        cmd_d1    = RW'(d1);
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
    endtask

    task automatic query(input int r, input int t);
        rd_reg = RW'(r);
        rd_tag = TAGW'(t);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_tag = '0;
        cmd_d0_en = 1'b0; cmd_d0 = '0; cmd_d1_en = 1'b0; cmd_d1 = '0;
        rd_reg = '0; rd_tag = '0; wr_reg = '0; wr_tag = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R11 reset state
        for (int r = 0; r < NREG; r += 15) begin
            query(r, 7);
            chk("R11 depth", int'(rd_depth), 0);
            chk("R11 rd_ok", int'(rd_ok), 1);
            chk("R11 fwd_ok", int'(fwd_ok), 0);
        end
        chk("R11 err_overflow", int'(err_overflow), 0);
        chk("R11 err_retire", int'(err_retire), 0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            rd_reg = VEC[i].qr; rd_tag = VEC[i].qt;
            wr_reg = VEC[i].qr; wr_tag = VEC[i].qt;
            do_cmd(int'(VEC[i].op), int'(VEC[i].tag), VEC[i].d0e, int'(VEC[i].d0),
                   VEC[i].d1e, int'(VEC[i].d1));
            chk("R2 rd_ok", int'(rd_ok), int'(VEC[i].e_rd));
            chk("R3 wr_ok", int'(wr_ok), int'(VEC[i].e_rd));
            chk("R4 fwd_ok", int'(fwd_ok), int'(VEC[i].e_fwd));
            chk("R4 fwd_tag", int'(fwd_tag), int'(VEC[i].e_ftag));
            chk("R9 byp_ok", int'(byp_ok), int'(VEC[i].e_byp));
            chk("R9 byp_tag", int'(byp_tag), int'(VEC[i].e_btag));
            chk("R1 depth", int'(rd_depth), int'(VEC[i].e_dep));
            chk("R10 err_overflow", int'(err_overflow), int'(VEC[i].e_ovf));
            chk("R6 err_retire", int'(err_retire), int'(VEC[i].e_ret));
        end

        // R4: a mark in the current cycle is not visible until after the edge
        do_cmd(0, 40, 1, 9, 0, 0);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd3; cmd_tag = 8'd40;
        cmd_d0_en = 1'b1; cmd_d0 = 5'd9; cmd_d1_en = 1'b0;
        rd_reg = 5'd9; rd_tag = 8'd41;
        #1;
        chk("R4 same-cycle mark hidden", int'(fwd_ok), 0);
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
        chk("R4 mark visible next cycle", int'(fwd_ok), 1);
        chk("R4 mark visible tag", int'(fwd_tag), 40);

        // R10: overflow on one list still appends to the other
        for (int t = 50; t < 54; t++) do_cmd(0, t, 1, 11, 0, 0);
        do_cmd(0, 54, 1, 11, 1, 12);
        chk("R10 err_overflow per list", int'(err_overflow), 1);
        query(11, 60);
        chk("R10 full list unchanged", int'(rd_depth), 4);
        query(12, 60);
        chk("R10 other list appended", int'(rd_depth), 1);

        // R3: write port judged on its own register
        rd_reg = 5'd12; rd_tag = 8'd60;
        wr_reg = 5'd11; wr_tag = 8'd50;
        #1;
        chk("R3 wr_ok at head", int'(wr_ok), 1);
        chk("R2 read port independent", int'(rd_ok), 0);
        wr_tag = 8'd51;
        #1;
        chk("R3 wr_ok younger", int'(wr_ok), 0);

        // R11: reset in mid-run empties everything
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        query(11, 60);
        chk("R11 depth after reset", int'(rd_depth), 0);
        query(9, 60);
        chk("R11 fwd after reset", int'(fwd_ok), 0);
        chk("R11 errors after reset", int'(err_overflow | err_retire), 0);

        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule